// File: doc/BRIEF.md
# String Primitive Repeat Sequencer

This block is a multi-cycle controller that carries out one string primitive on behalf of a processor core: copy, compare, scan, load or store, on bytes or on 16-bit words. The core issues a one-cycle `start` with the operation, the element size, the repeat mode, the direction bit and the current source index, destination index, count and accumulator. The sequencer then walks memory element by element through a request/ready port. A `seg_dst` select tells the memory which segment applies: the source segment for source-index accesses and the destination segment for destination-index accesses. When it finishes, it raises `done` for one cycle and presents the updated indices, count, accumulator and six arithmetic flags.

The block has four repeat modes. In single mode the primitive runs exactly once and the count is left alone. In unconditional mode it repeats until the count is exhausted. In the two conditional modes it also stops on the zero flag after a compare or scan. The count is tested before every iteration, so a zero count ends the operation without touching memory. The zero flag is tested after every compare or scan iteration.

Internally a state machine moves through the states IDLE, CHECK, RD_SRC, RD_DST, WR_DST, STEP and FINISH. The transitions are:

- IDLE goes to CHECK on `start`.
- CHECK goes to FINISH when a repeat mode is active and the count is zero. Otherwise it goes to the first access of the operation: RD_SRC for copy, compare and load, RD_DST for scan, and WR_DST for store.
- RD_SRC goes to WR_DST for copy, to RD_DST for compare, and to STEP for load. Each of these moves happens when `mem_rdy` is seen.
- RD_DST and WR_DST go to STEP when `mem_rdy` is seen.
- STEP goes back to CHECK when the repeat continues, and to FINISH otherwise.
- FINISH returns to IDLE.

Top module: `strop_seq`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are all 0.
- R2: In any repeat mode (`rep` not 0), if the count is zero when an iteration would begin, the operation finishes with no memory access. All indices, the count, the accumulator and the flags are returned unchanged.
- R3: In single mode (`rep`=0) exactly one iteration runs, `cx_out` equals `cx_in`, and the zero flag does not end or extend the operation.
- R4: After each element, an index that the operation uses moves by 1 for bytes (`wide`=0) or by 2 for words (`wide`=1). It increases when `dir`=0 and decreases when `dir`=1.
- R5: Copy (`op`=0) reads the source segment at SI and writes that element to the destination segment at DI, then advances both indices. Words are little-endian: low byte at the index, high byte at index+1.
- R6: Load (`op`=3) reads the source segment at SI into the accumulator and advances only SI. A byte load replaces only `acc` bits 7:0 and keeps bits 15:8.
- R7: Store (`op`=4) writes the accumulator (bits 7:0 for bytes) to the destination segment at DI and advances only DI.
- R8: Compare (`op`=1) forms source[SI] minus destination[DI] at the element size and advances both indices; nothing is written. The result sets `flags_out` as {OF,SF,ZF,AF,PF,CF} on bits 5..0:
  - CF is the borrow out of the element.
  - ZF is set when the difference is zero.
  - SF is the top bit of the difference.
  - OF is signed overflow.
  - AF is the borrow out of bit 3.
  - PF is 1 when the low 8 bits of the difference hold an even number of ones.
- R9: Scan (`op`=2) forms destination[DI] minus the accumulator with the same flag rules as R8, and advances only DI.
- R10: Repeat mode 2 continues a compare or scan only while ZF=1, and mode 3 only while ZF=0. Mode 1 applied to compare or scan behaves as mode 2.
- R11: Every repeated iteration decrements the count by one. In mode 1, copy, load and store run exactly `cx_in` iterations and end with a count of 0.
- R12: Each access holds `mem_req` high, with `mem_addr`, `seg_dst` and `mem_we` stable, until `mem_rdy`. A word is one request at the current index with `mem_wide`=1.
- R13: `busy` is high from the cycle after `start` until the single-cycle `done` pulse, and is low in the cycle after it. Copy, load and store leave `flags_out` equal to `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch of an operation (taken when idle) |
| op | input | 3 | 0 copy, 1 compare, 2 scan, 3 load, 4 store |
| wide | input | 1 | 0 byte elements, 1 word elements |
| rep | input | 2 | 0 single, 1 unconditional, 2 while equal, 3 while not equal |
| dir | input | 1 | 0 ascending indices, 1 descending |
| si_in | input | 16 | Initial source index |
| di_in | input | 16 | Initial destination index |
| cx_in | input | 16 | Initial count |
| acc_in | input | 16 | Initial accumulator |
| flags_in | input | 6 | Initial flags {OF,SF,ZF,AF,PF,CF} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| si_out | output | 16 | Updated source index |
| di_out | output | 16 | Updated destination index |
| cx_out | output | 16 | Updated count |
| acc_out | output | 16 | Updated accumulator |
| flags_out | output | 6 | Updated flags {OF,SF,ZF,AF,PF,CF} |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| seg_dst | output | 1 | 0 source segment, 1 destination segment |
| mem_wide | output | 1 | 1 word access, 0 byte access |
| mem_addr | output | 16 | Access offset |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_rdy | input | 1 | Access completes in this cycle |

## Verification
The two exits of a conditional repeat can fall on the same iteration: the count can reach zero in the STEP state where a compare has just cleared or set ZF. The bench provokes this with a while-equal compare of three elements in two runs. In the first run the buffers match everywhere. In the second run only the last element differs. Each run is judged by the final count (0), the final ZF (1 in the first run, 0 in the second), the index advance of three elements, and exactly six memory accesses. This confirms that neither exit adds or drops an iteration.

// File: rtl/strop_pkg.sv
package strop_pkg;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_CMP   = 3'd1,
        OP_SCAN  = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        RP_ONCE = 2'd0,
        RP_ALL  = 2'd1,
        RP_EQ   = 2'd2,
        RP_NE   = 2'd3
    } rep_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_RDSRC,
        S_RDDST,
        S_WRDST,
        S_STEP,
        S_FIN
    } state_e;

    localparam int FL_CF = 0;
    localparam int FL_PF = 1;
    localparam int FL_AF = 2;
    localparam int FL_ZF = 3;
    localparam int FL_SF = 4;
    localparam int FL_OF = 5;
    localparam int FL_W  = 6;

endpackage

// File: rtl/strop_alu.sv
module strop_alu
    import strop_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            wide,
    output logic [FL_W-1:0] fl
);
    localparam int HW = DW / 2;

    logic [DW:0]   diff_w;
    logic [HW:0]   diff_b;
    logic [DW-1:0] res;

    always_comb begin
        diff_w = {1'b0, a} - {1'b0, b};
        diff_b = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]};
        fl     = '0;
        if (wide) begin
            res       = diff_w[DW-1:0];
            fl[FL_CF] = diff_w[DW];
            fl[FL_ZF] = (diff_w[DW-1:0] == '0);
            fl[FL_SF] = diff_w[DW-1];
            fl[FL_OF] = (a[DW-1] ^ b[DW-1]) & (diff_w[DW-1] ^ a[DW-1]);
        end else begin
            res       = {{HW{1'b0}}, diff_b[HW-1:0]};
            fl[FL_CF] = diff_b[HW];
            fl[FL_ZF] = (diff_b[HW-1:0] == '0);
            fl[FL_SF] = diff_b[HW-1];
            fl[FL_OF] = (a[HW-1] ^ b[HW-1]) & (diff_b[HW-1] ^ a[HW-1]);
        end
        fl[FL_AF] = a[4] ^ b[4] ^ res[4];
        fl[FL_PF] = ~^res[7:0];
    end
endmodule

// File: rtl/strop_idx.sv
module strop_idx #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] idx,
    input  logic          dir,
    input  logic          wide,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] step;

    always_comb begin
        step = wide ? AW'(2) : AW'(1);
        nxt  = dir ? (idx - step) : (idx + step);
    end
endmodule

// File: rtl/strop_seq.sv
module strop_seq
    import strop_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic            wide,
    input  logic [1:0]      rep,
    input  logic            dir,
    input  logic [AW-1:0]   si_in,
    input  logic [AW-1:0]   di_in,
    input  logic [CW-1:0]   cx_in,
    input  logic [DW-1:0]   acc_in,
    input  logic [FL_W-1:0] flags_in,
    output logic            busy,
    output logic            done,
    output logic [AW-1:0]   si_out,
    output logic [AW-1:0]   di_out,
    output logic [CW-1:0]   cx_out,
    output logic [DW-1:0]   acc_out,
    output logic [FL_W-1:0] flags_out,
    output logic            mem_req,
    output logic            mem_we,
    output logic            seg_dst,
    output logic            mem_wide,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_rdy
);
    localparam int HW = DW / 2;

    state_e          st, st_nx;
    op_e             op_q;
    rep_e            rep_q;
    logic            wide_q, dir_q;
    logic [AW-1:0]   si_q, di_q, si_nx, di_nx;
    logic [CW-1:0]   cx_q;
    logic [DW-1:0]   acc_q, tmp_q, rd_val, acc_v, alu_a, alu_b;
    logic [FL_W-1:0] fl_q, alu_fl;
    logic            eq_mode, cont, adv_si, adv_di;

    // index steppers, one per pointer
    strop_idx #(.AW(AW)) u_si (.idx(si_q), .dir(dir_q), .wide(wide_q), .nxt(si_nx));
    strop_idx #(.AW(AW)) u_di (.idx(di_q), .dir(dir_q), .wide(wide_q), .nxt(di_nx));

    assign rd_val = wide_q ? mem_rdata : {{HW{1'b0}}, mem_rdata[HW-1:0]};
    assign acc_v  = wide_q ? acc_q : {{HW{1'b0}}, acc_q[HW-1:0]};
    assign alu_a  = (op_q == OP_CMP) ? tmp_q : rd_val;
    assign alu_b  = (op_q == OP_CMP) ? rd_val : acc_v;

    strop_alu #(.DW(DW)) u_alu (.a(alu_a), .b(alu_b), .wide(wide_q), .fl(alu_fl));

    assign eq_mode = (rep_q == RP_ALL) || (rep_q == RP_EQ);
    assign adv_si  = (op_q == OP_MOVE) || (op_q == OP_CMP) || (op_q == OP_LOAD);
    assign adv_di  = (op_q != OP_LOAD);

    always_comb begin
        if (rep_q == RP_ONCE)
            cont = 1'b0;
        else if ((op_q == OP_CMP) || (op_q == OP_SCAN))
            cont = eq_mode ? fl_q[FL_ZF] : ~fl_q[FL_ZF];
        else
            cont = 1'b1;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (start) st_nx = S_CHECK;
            S_CHECK: begin
                if ((rep_q != RP_ONCE) && (cx_q == '0))
                    st_nx = S_FIN;
                else begin
                    unique case (op_q)
                        OP_MOVE, OP_CMP, OP_LOAD: st_nx = S_RDSRC;
                        OP_SCAN:                  st_nx = S_RDDST;
                        OP_STORE:                 st_nx = S_WRDST;
                        default:                  st_nx = S_FIN;
                    endcase
                end
            end
            S_RDSRC: if (mem_rdy) begin
                unique case (op_q)
                    OP_MOVE: st_nx = S_WRDST;
                    OP_CMP:  st_nx = S_RDDST;
                    default: st_nx = S_STEP;
                endcase
            end
            S_RDDST: if (mem_rdy) st_nx = S_STEP;
            S_WRDST: if (mem_rdy) st_nx = S_STEP;
            S_STEP:  st_nx = cont ? S_CHECK : S_FIN;
            S_FIN:   st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_MOVE;
            rep_q  <= RP_ONCE;
            wide_q <= 1'b0;
            dir_q  <= 1'b0;
            si_q   <= '0;
            di_q   <= '0;
            cx_q   <= '0;
            acc_q  <= '0;
            tmp_q  <= '0;
            fl_q   <= '0;
        end else begin
            if ((st == S_IDLE) && start) begin
                op_q   <= op_e'(op);
                rep_q  <= rep_e'(rep);
                wide_q <= wide;
                dir_q  <= dir;
                si_q   <= si_in;
                di_q   <= di_in;
                cx_q   <= cx_in;
                acc_q  <= acc_in;
                fl_q   <= flags_in;
            end
            if ((st == S_RDSRC) && mem_rdy) begin
                tmp_q <= rd_val;
                if (op_q == OP_LOAD)
                    acc_q <= wide_q ? mem_rdata : {acc_q[DW-1:HW], mem_rdata[HW-1:0]};
            end
            if ((st == S_RDDST) && mem_rdy)
                fl_q <= alu_fl;
            if (st == S_STEP) begin
                if (adv_si) si_q <= si_nx;
                if (adv_di) di_q <= di_nx;
                if (rep_q != RP_ONCE) cx_q <= cx_q - CW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        seg_dst   = 1'b0;
        mem_addr  = si_q;
        mem_wdata = (op_q == OP_MOVE) ? tmp_q : acc_q;
        mem_wide  = wide_q;
        unique case (st)
            S_RDSRC: begin
                mem_req = 1'b1;
            end
            S_RDDST: begin
                mem_req  = 1'b1;
                seg_dst  = 1'b1;
                mem_addr = di_q;
            end
            S_WRDST: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                seg_dst  = 1'b1;
                mem_addr = di_q;
            end
            default: ;
        endcase
    end

    assign busy      = (st != S_IDLE);
    assign done      = (st == S_FIN);
    assign si_out    = si_q;
    assign di_out    = di_q;
    assign cx_out    = cx_q;
    assign acc_out   = acc_q;
    assign flags_out = fl_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(seg_dst) && $stable(mem_we))); // R12

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R13

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R1

    AST_ZERO_COUNT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_CHECK) && (rep_q != RP_ONCE) && (cx_q == '0)) |=> (done && !mem_req)); // R2

    AST_ONCE_CX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((rep_q == RP_ONCE) && busy && $past(busy)) |-> $stable(cx_out)); // R3

    AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_q == OP_MOVE || op_q == OP_LOAD || op_q == OP_STORE) && busy && $past(busy)) |-> $stable(flags_out)); // R13

endmodule

// File: tb/sim_strop_seq.sv
module sim_strop_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic        wide = 1'b0;
    logic [1:0]  rep = '0;
    logic        dir = 1'b0;
    logic [15:0] si_in = '0, di_in = '0, cx_in = '0, acc_in = '0;
    logic [5:0]  flags_in = '0;
    logic        busy, done, mem_req, mem_we, seg_dst, mem_wide;
    logic [15:0] si_out, di_out, cx_out, acc_out, mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_rdy = 1'b0;
    logic [5:0]  flags_out;

    logic [7:0]  msrc [0:255];
    logic [7:0]  mdst [0:255];
    int          lat = 0;
    int          wcnt = 0;
    int          naccess = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cycles = 0;
    bit          ended = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    strop_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide), .rep(rep), .dir(dir),
        .si_in(si_in), .di_in(di_in), .cx_in(cx_in), .acc_in(acc_in), .flags_in(flags_in),
        .busy(busy), .done(done), .si_out(si_out), .di_out(di_out), .cx_out(cx_out),
        .acc_out(acc_out), .flags_out(flags_out), .mem_req(mem_req), .mem_we(mem_we),
        .seg_dst(seg_dst), .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
    );

    // memory model: ready after lat+1 cycles, write committed at completing edge
    always @(posedge clk) begin
        if (mem_rdy) begin
            mem_rdy <= 1'b0;
            naccess <= naccess + 1;
            if (mem_we) begin
                if (seg_dst) begin
                    mdst[mem_addr[7:0]] = mem_wdata[7:0];
                    if (mem_wide) mdst[mem_addr[7:0] + 8'd1] = mem_wdata[15:8];
                end else begin
                    msrc[mem_addr[7:0]] = mem_wdata[7:0];
                    if (mem_wide) msrc[mem_addr[7:0] + 8'd1] = mem_wdata[15:8];
                end
            end
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                wcnt    <= 0;
                mem_rdy <= 1'b1;
                if (seg_dst)
                    mem_rdata <= {mem_wide ? mdst[mem_addr[7:0] + 8'd1] : 8'h00, mdst[mem_addr[7:0]]};
                else
                    mem_rdata <= {mem_wide ? msrc[mem_addr[7:0] + 8'd1] : 8'h00, msrc[mem_addr[7:0]]};
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual running expected finished");
            finish_run();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] subf(input logic [15:0] a, input logic [15:0] b, input logic w);
        logic [16:0] d;
        logic [15:0] r;
        logic of, sf, zf, cf;
        if (w) begin
            d  = {1'b0, a} - {1'b0, b};
            r  = d[15:0];
            cf = d[16]; sf = r[15]; zf = (r == 0);
            of = (a[15] ^ b[15]) & (r[15] ^ a[15]);
        end else begin
            d  = {9'b0, a[7:0]} - {9'b0, b[7:0]};
            r  = {8'h00, d[7:0]};
            cf = d[8]; sf = r[7]; zf = (r[7:0] == 0);
            of = (a[7] ^ b[7]) & (r[7] ^ a[7]);
        end
        return {of, sf, zf, a[4] ^ b[4] ^ r[4], ~^r[7:0], cf};
    endfunction

    task automatic go(input logic [2:0] o, input logic w, input logic [1:0] r, input logic d,
                      input logic [15:0] s, input logic [15:0] t, input logic [15:0] c,
                      input logic [15:0] a, input logic [5:0] f);
        int guard;
        @(negedge clk);
        op = o; wide = w; rep = r; dir = d;
        si_in = s; di_in = t; cx_in = c; acc_in = a; flags_in = f;
        naccess = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R13 busy after start", {31'b0, busy}, 32'd1);
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk("R13 done reached", {31'b0, done}, 32'd1);
    endtask

    task automatic after_done();
        @(negedge clk);
        chk("R13 single-cycle done", {30'b0, done, busy}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 reset busy/done/req", {29'b0, busy, done, mem_req}, 32'd0);
    endtask

    task automatic t_cx_zero();
        go(3'd0, 1'b0, 2'd1, 1'b0, 16'h0010, 16'h0030, 16'h0000, 16'h1234, 6'b101010);
        chk("R2 no access", naccess, 0);
        chk("R2 si", si_out, 16'h0010);
        chk("R2 di", di_out, 16'h0030);
        chk("R2 cx", cx_out, 16'h0000);
        chk("R2 flags", flags_out, 6'b101010);
        after_done();
    endtask

    task automatic t_move_rep_byte();
        for (int i = 0; i < 4; i++) begin msrc[8'h10 + i] = 8'hA0 + 8'(i); mdst[8'h30 + i] = 8'h00; end
        mdst[8'h34] = 8'h5E;
        go(3'd0, 1'b0, 2'd1, 1'b0, 16'h0010, 16'h0030, 16'd4, 16'h0000, 6'b010101);
        for (int i = 0; i < 4; i++) chk("R5 copied byte", mdst[8'h30 + i], 8'hA0 + 8'(i));
        chk("R11 beyond count untouched", mdst[8'h34], 8'h5E);
        chk("R11 cx zero", cx_out, 0);
        chk("R4 si ascending byte", si_out, 16'h0014);
        chk("R4 di ascending byte", di_out, 16'h0034);
        chk("R13 flags kept", flags_out, 6'b010101);
        chk("R11 access count", naccess, 8);
        after_done();
    endtask

    task automatic t_move_word_desc();
        msrc[8'h40] = 8'h11; msrc[8'h41] = 8'h22; msrc[8'h3E] = 8'h33; msrc[8'h3F] = 8'h44;
        lat = 2;
        go(3'd0, 1'b1, 2'd1, 1'b1, 16'h0040, 16'h0060, 16'd2, 16'h0000, 6'b000000);
        lat = 0;
        chk("R5 word low", mdst[8'h60], 8'h11);
        chk("R5 word high", mdst[8'h61], 8'h22);
        chk("R5 second word", {mdst[8'h5F], mdst[8'h5E]}, 16'h4433);
        chk("R4 si descending word", si_out, 16'h003C);
        chk("R4 di descending word", di_out, 16'h005C);
        chk("R12 one request per word", naccess, 4);
        after_done();
    endtask

    task automatic t_load_byte();
        msrc[8'h20] = 8'h5A;
        go(3'd3, 1'b0, 2'd0, 1'b0, 16'h0020, 16'h0070, 16'd9, 16'h12FF, 6'b111111);
        chk("R6 byte load keeps high", acc_out, 16'h125A);
        chk("R6 si step", si_out, 16'h0021);
        chk("R6 di unchanged", di_out, 16'h0070);
        chk("R3 cx unchanged", cx_out, 16'd9);
        chk("R13 flags kept on load", flags_out, 6'b111111);
        after_done();
    endtask

    task automatic t_store_word();
        go(3'd4, 1'b1, 2'd0, 1'b1, 16'h0005, 16'h0080, 16'd3, 16'hBEEF, 6'b000000);
        chk("R7 store word", {mdst[8'h81], mdst[8'h80]}, 16'hBEEF);
        chk("R7 di step down", di_out, 16'h007E);
        chk("R7 si unchanged", si_out, 16'h0005);
        chk("R3 single access", naccess, 1);
        after_done();
    endtask

    task automatic t_cmp_single();
        msrc[8'h90] = 8'h05; mdst[8'h90] = 8'h07;
        go(3'd1, 1'b0, 2'd0, 1'b0, 16'h0090, 16'h0090, 16'd5, 16'h0000, 6'b000000);
        chk("R8 cmp flags", flags_out, subf(16'h0005, 16'h0007, 1'b0));
        chk("R8 cmp flags literal", flags_out, 6'b010101);
        chk("R3 cx kept on cmp", cx_out, 16'd5);
        chk("R8 both indices", {si_out, di_out}, {16'h0091, 16'h0091});
        chk("R8 no write", mdst[8'h90], 8'h07);
        after_done();
    endtask

    task automatic t_repe_cmp();
        msrc[8'hA0] = 8'h41; msrc[8'hA1] = 8'h42; msrc[8'hA2] = 8'h43; msrc[8'hA3] = 8'h58;
        mdst[8'hA0] = 8'h41; mdst[8'hA1] = 8'h42; mdst[8'hA2] = 8'h43; mdst[8'hA3] = 8'h44;
        go(3'd1, 1'b0, 2'd2, 1'b0, 16'h00A0, 16'h00A0, 16'd10, 16'h0000, 6'b000000);
        chk("R10 while-equal stop cx", cx_out, 16'd6);
        chk("R10 while-equal zf clear", flags_out[3], 1'b0);
        chk("R10 while-equal si", si_out, 16'h00A4);
        after_done();
    endtask

    task automatic t_rep_cmp_as_eq();
        msrc[8'hB0] = 8'h01; msrc[8'hB1] = 8'h02;
        mdst[8'hB0] = 8'h01; mdst[8'hB1] = 8'h09;
        go(3'd1, 1'b0, 2'd1, 1'b0, 16'h00B0, 16'h00B0, 16'd7, 16'h0000, 6'b000000);
        chk("R10 unconditional cmp acts as equal", cx_out, 16'd5);
        chk("R10 zf", flags_out[3], 1'b0);
    endtask

    task automatic t_repne_scan();
        mdst[8'hC0] = 8'h11; mdst[8'hC1] = 8'h22; mdst[8'hC2] = 8'h33; mdst[8'hC3] = 8'h44;
        go(3'd2, 1'b0, 2'd3, 1'b0, 16'h0001, 16'h00C0, 16'd8, 16'h7733, 6'b000000);
        chk("R9 scan hit cx", cx_out, 16'd5);
        chk("R9 scan di", di_out, 16'h00C3);
        chk("R9 scan si fixed", si_out, 16'h0001);
        chk("R10 while-not-equal zf set", flags_out[3], 1'b1);
        chk("R9 scan acc kept", acc_out, 16'h7733);
    endtask

    task automatic t_scan_word_ovf();
        mdst[8'hD0] = 8'h00; mdst[8'hD1] = 8'h80;
        go(3'd2, 1'b1, 2'd0, 1'b0, 16'h0000, 16'h00D0, 16'd1, 16'h0001, 6'b000000);
        chk("R9 word scan flags", flags_out, subf(16'h8000, 16'h0001, 1'b1));
        chk("R8 overflow literal", flags_out, 6'b100110);
        chk("R4 di word step", di_out, 16'h00D2);
    endtask

    task automatic t_coincide();
        for (int i = 0; i < 3; i++) begin msrc[8'hE0 + i] = 8'h30 + 8'(i); mdst[8'hE0 + i] = 8'h30 + 8'(i); end
        go(3'd1, 1'b0, 2'd2, 1'b0, 16'h00E0, 16'h00E0, 16'd3, 16'h0000, 6'b000000);
        chk("R11 equal run cx", cx_out, 0);
        chk("R10 equal run zf", flags_out[3], 1'b1);
        chk("R11 equal run accesses", naccess, 6);
        mdst[8'hE2] = 8'h7F;
        go(3'd1, 1'b0, 2'd2, 1'b0, 16'h00E0, 16'h00E0, 16'd3, 16'h0000, 6'b000000);
        chk("R11 last-miss cx", cx_out, 0);
        chk("R10 last-miss zf", flags_out[3], 1'b0);
        chk("R4 last-miss si", si_out, 16'h00E3);
        chk("R11 last-miss accesses", naccess, 6);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin msrc[i] = 8'h00; mdst[i] = 8'h00; end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cx_zero();
        t_move_rep_byte();
        t_move_word_desc();
        t_load_byte();
        t_store_word();
        t_cmp_single();
        t_repe_cmp();
        t_rep_cmp_as_eq();
        t_repne_scan();
        t_scan_word_ovf();
        t_coincide();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule